// File: doc/BRIEF.md
# Multi-master region access checker

This block decides, for every bus access, whether the issuing master may touch the addressed location. The access arrives with an address, a master number, a kind (read, write or instruction fetch), a user/supervisor mode bit, a process identifier and the number of the slave port it targets. The block compares it against a set of region descriptors. Each descriptor gives an address window, a valid bit, per-master rights and a process-identifier tag with a don't-care mask. One clock later the block returns a grant or a deny. The descriptors are held elsewhere and reach the block as flat input vectors.

Masters fall into two classes. Privileged masters have a three-bit user rights field, a two-bit supervisor rights field and an optional process-identifier qualifier. Plain masters have only read and write enables. When an access is denied while protection is on, the block records the details for the targeted slave port and raises that port's pending flag. Each port has a two-state log machine, `LOG_IDLE` and `LOG_HELD`, with three transitions:

- `CAPTURE` moves from `LOG_IDLE` to `LOG_HELD` and loads the details.
- `RELEASE` moves from `LOG_HELD` to `LOG_IDLE` on a write-one-to-clear.
- `RELOAD` stays in `LOG_HELD` and loads the new details when a clear and a new deny arrive in the same cycle.

Top module: `region_access_checker`

## Requirements
- R1: A region hits only when its valid bit is set and the address lies inclusively between its bounds. The start bound is taken with its low GRAIN_BITS bits forced to 0 and the end bound with its low GRAIN_BITS bits forced to 1. With the defaults, start 0x0123 and end 0x0145 cover 0x0120..0x015F.
- R2: For privileged masters (0..PRIV_MASTERS-1) in user mode (`acc_super`=0), the user field in bits [2:0] of the master's 6-bit rights slot is used: bit 2 allows read, bit 1 allows write and bit 0 allows fetch.
- R3: For privileged masters in supervisor mode, the supervisor field in bits [4:3] selects the rights: 0 gives read/write/fetch, 1 gives read/fetch, 2 gives read/write, and 3 uses the user field.
- R4: For plain masters (PRIV_MASTERS..NUM_MASTERS-1), the 2-bit slot is used: bit 1 allows read and bit 0 allows write. A fetch by a plain master is never allowed.
- R5: When bit 5 of a privileged master's slot is set, the region hits for that master only if the access process identifier equals the region tag on every bit where the tag mask is 0.
- R6: An access is granted when at least one hitting region allows it. `resp_valid` and `resp_grant` appear on the clock edge after `acc_valid`. `resp_valid` is low in every other cycle.
- R7: While `prot_en` is 0, every access is granted and no error is logged.
- R8: The logged class is 0 when no region hit, 1 when exactly one region hit and 2 when two or more regions hit. The value 3 is never logged.
- R9: A deny on port p (p < NUM_PORTS) is logged with its details, one edge after `acc_valid`:
  - the address and the master number;
  - the attribute {acc_super, not-fetch}: 0 user fetch, 1 user data, 2 supervisor fetch, 3 supervisor data;
  - a write bit that is 1 only for writes (a fetch counts as a read).

  The deny sets `err_pend[NUM_PORTS-1-p]`. A port number ≥ NUM_PORTS logs nothing.
- R10: While a port's flag is set, later denies on that port leave its logged details unchanged.
- R11: Writing 1 to `err_clr[NUM_PORTS-1-p]` (same bit order as the flags) clears port p's flag on the next edge. If a deny on port p arrives in the same cycle as the clear, the flag stays set and the new details are loaded.
- R12: After reset, all flags, `resp_valid` and `resp_grant` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_en | input | 1 | Global protection enable |
| rgn_valid | input | NUM_REGIONS | Region valid bits |
| rgn_lo | input | NUM_REGIONS*ADDR_W | Region start bounds, region r at slice r |
| rgn_hi | input | NUM_REGIONS*ADDR_W | Region end bounds |
| rgn_xperm | input | NUM_REGIONS*PRIV_MASTERS*6 | Privileged rights: [2:0] user, [4:3] supervisor, [5] process-ID qualify |
| rgn_rwperm | input | NUM_REGIONS*(NUM_MASTERS-PRIV_MASTERS)*2 | Plain rights: [1] read, [0] write |
| rgn_tag | input | NUM_REGIONS*PID_W | Region process-ID tag |
| rgn_tagmask | input | NUM_REGIONS*PID_W | Tag don't-care mask (1 = ignore bit) |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_master | input | MASTER_W | Master number |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 treated as read |
| acc_super | input | 1 | 1 = supervisor mode |
| acc_pid | input | PID_W | Access process identifier |
| acc_port | input | PORT_W | Targeted slave port |
| resp_valid | output | 1 | Verdict valid |
| resp_grant | output | 1 | 1 = granted |
| err_pend | output | NUM_PORTS | Pending flags, port p at bit NUM_PORTS-1-p |
| err_clr | input | NUM_PORTS | Write-one-to-clear, same order as err_pend |
| err_addr | output | NUM_PORTS*ADDR_W | Logged address, port p at slice p |
| err_master | output | NUM_PORTS*MASTER_W | Logged master |
| err_attr | output | NUM_PORTS*2 | Logged mode/kind attribute |
| err_write | output | NUM_PORTS | Logged write bit |
| err_class | output | NUM_PORTS*2 | Logged region-hit class |

## Verification
The bench sweeps every user and supervisor rights code against every access kind and mode for each privileged master. It also sweeps every enable pair for each plain master. A swapped bit in a rights field, or a supervisor code mapped to the wrong set, shows up there as a wrong verdict. Probes on both sides of each granule-widened bound catch a design that compares raw bounds or excludes the end address. Targeted cases cover masked tag matches and the three hit classes. They also cover a second deny while a port is held, which a design that overwrites would lose. A clear and a deny arriving in the same cycle is tested too: a design that lets the clear win drops the new error. Flags are read by bit position, so a design that does not reverse the port order raises the wrong bit.

// File: rtl/rac_pkg.sv
package rac_pkg;

    localparam logic [1:0] KIND_READ  = 2'd0;
    localparam logic [1:0] KIND_WRITE = 2'd1;
    localparam logic [1:0] KIND_FETCH = 2'd2;

    localparam logic [1:0] CLS_NONE   = 2'd0;
    localparam logic [1:0] CLS_SINGLE = 2'd1;
    localparam logic [1:0] CLS_MULTI  = 2'd2;

    localparam int XSLOT_W  = 6;
    localparam int RWSLOT_W = 2;

    typedef enum logic {
        LOG_IDLE = 1'b0,
        LOG_HELD = 1'b1
    } log_state_e;

    // rights vector: [2] read, [1] write, [0] fetch
    function automatic logic [2:0] super_rights(input logic [1:0] code, input logic [2:0] user);
        logic [2:0] r;
        unique case (code)
            2'd0: r = 3'b111;
            2'd1: r = 3'b101;
            2'd2: r = 3'b110;
            default: r = user;
        endcase
        return r;
    endfunction

    function automatic logic rights_allow(input logic [2:0] r, input logic [1:0] kind);
        logic ok;
        if (kind == KIND_FETCH)      ok = r[0];
        else if (kind == KIND_WRITE) ok = r[1];
        else                         ok = r[2];
        return ok;
    endfunction

endpackage

// File: rtl/rac_region_eval.sv
module rac_region_eval
    import rac_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int PID_W        = 8,
    parameter int MASTER_W     = 3,
    parameter int PRIV_MASTERS = 4,
    parameter int NUM_MASTERS  = 8,
    parameter int GRAIN_BITS   = 5
) (
    input  logic                                     valid,
    input  logic [ADDR_W-1:0]                        lo,
    input  logic [ADDR_W-1:0]                        hi,
    input  logic [PRIV_MASTERS*XSLOT_W-1:0]          xperm,
    input  logic [(NUM_MASTERS-PRIV_MASTERS)*RWSLOT_W-1:0] rwperm,
    input  logic [PID_W-1:0]                         tag,
    input  logic [PID_W-1:0]                         tagmask,
    input  logic [ADDR_W-1:0]                        addr,
    input  logic [MASTER_W-1:0]                      master,
    input  logic [1:0]                               kind,
    input  logic                                     sup,
    input  logic [PID_W-1:0]                         pid,
    output logic                                     hit,
    output logic                                     allow
);

    localparam int PLAIN_MASTERS = NUM_MASTERS - PRIV_MASTERS;

    logic [ADDR_W-1:0]   lo_eff;
    logic [ADDR_W-1:0]   hi_eff;
    logic [XSLOT_W-1:0]  xslot;
    logic [RWSLOT_W-1:0] rwslot;
    logic                is_priv;
    logic                is_plain;
    logic                tag_ok;
    logic [2:0]          eff;

    assign lo_eff = {lo[ADDR_W-1:GRAIN_BITS], {GRAIN_BITS{1'b0}}};
    assign hi_eff = {hi[ADDR_W-1:GRAIN_BITS], {GRAIN_BITS{1'b1}}};

    always_comb begin
        xslot    = '0;
        rwslot   = '0;
        is_priv  = 1'b0;
        is_plain = 1'b0;
        for (int m = 0; m < PRIV_MASTERS; m++) begin
            if (master == MASTER_W'(m)) begin
                xslot   = xperm[m*XSLOT_W +: XSLOT_W];
                is_priv = 1'b1;
            end
        end
        for (int m = 0; m < PLAIN_MASTERS; m++) begin
            if (master == MASTER_W'(PRIV_MASTERS + m)) begin
                rwslot   = rwperm[m*RWSLOT_W +: RWSLOT_W];
                is_plain = 1'b1;
            end
        end
    end

    assign tag_ok = !(is_priv && xslot[5]) || (((pid ^ tag) & ~tagmask) == '0);
    assign hit    = valid && (addr >= lo_eff) && (addr <= hi_eff) && tag_ok;

    always_comb begin
        eff = sup ? super_rights(xslot[4:3], xslot[2:0]) : xslot[2:0];
        if (is_priv)
            allow = rights_allow(eff, kind);
        else if (is_plain)
            allow = rights_allow({rwslot[1], rwslot[0], 1'b0}, kind);
        else
            allow = 1'b0;
    end

endmodule

// File: rtl/rac_verdict.sv
module rac_verdict
    import rac_pkg::*;
#(
    parameter int NUM_REGIONS = 4
) (
    input  logic                   prot_en,
    input  logic [NUM_REGIONS-1:0] hit_v,
    input  logic [NUM_REGIONS-1:0] allow_v,
    output logic                   grant,
    output logic [1:0]             cls
);

    localparam int CNT_W = $clog2(NUM_REGIONS + 1);

    logic [CNT_W-1:0] n_hit;

    always_comb begin
        n_hit = '0;
        for (int r = 0; r < NUM_REGIONS; r++)
            n_hit = n_hit + CNT_W'(hit_v[r]);
    end

    assign grant = !prot_en || ((hit_v & allow_v) != '0);

    always_comb begin
        if (n_hit == '0)                cls = CLS_NONE;
        else if (n_hit == CNT_W'(1))    cls = CLS_SINGLE;
        else                            cls = CLS_MULTI;
    end

endmodule

// File: rtl/rac_port_log.sv
module rac_port_log
    import rac_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int MASTER_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                deny,
    input  logic                clr,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [MASTER_W-1:0] in_master,
    input  logic [1:0]          in_attr,
    input  logic                in_write,
    input  logic [1:0]          in_cls,
    output logic                pend,
    output logic [ADDR_W-1:0]   q_addr,
    output logic [MASTER_W-1:0] q_master,
    output logic [1:0]          q_attr,
    output logic                q_write,
    output logic [1:0]          q_cls
);

    log_state_e state;
    log_state_e state_nxt;
    logic       load;

    // transitions: CAPTURE, RELEASE, RELOAD
    always_comb begin
        state_nxt = state;
        load      = 1'b0;
        unique case (state)
            LOG_IDLE: begin
                if (deny) begin
                    state_nxt = LOG_HELD;
                    load      = 1'b1;
                end
            end
            LOG_HELD: begin
                if (clr) begin
                    if (deny) load = 1'b1;
                    else      state_nxt = LOG_IDLE;
                end
            end
            default: state_nxt = LOG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= LOG_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr   <= '0;
            q_master <= '0;
            q_attr   <= '0;
            q_write  <= 1'b0;
            q_cls    <= '0;
        end else if (load) begin
            q_addr   <= in_addr;
            q_master <= in_master;
            q_attr   <= in_attr;
            q_write  <= in_write;
            q_cls    <= in_cls;
        end
    end

    assign pend = (state == LOG_HELD);

endmodule

// File: rtl/region_access_checker.sv
module region_access_checker
    import rac_pkg::*;
#(
    parameter int NUM_REGIONS  = 4,
    parameter int ADDR_W       = 16,
    parameter int PID_W        = 8,
    parameter int MASTER_W     = 3,
    parameter int PRIV_MASTERS = 4,
    parameter int NUM_MASTERS  = 8,
    parameter int NUM_PORTS    = 5,
    parameter int GRAIN_BITS   = 5,
    parameter int PORT_W       = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  prot_en,
    input  logic [NUM_REGIONS-1:0]                rgn_valid,
    input  logic [NUM_REGIONS*ADDR_W-1:0]         rgn_lo,
    input  logic [NUM_REGIONS*ADDR_W-1:0]         rgn_hi,
    input  logic [NUM_REGIONS*PRIV_MASTERS*6-1:0] rgn_xperm,
    input  logic [NUM_REGIONS*(NUM_MASTERS-PRIV_MASTERS)*2-1:0] rgn_rwperm,
    input  logic [NUM_REGIONS*PID_W-1:0]          rgn_tag,
    input  logic [NUM_REGIONS*PID_W-1:0]          rgn_tagmask,
    input  logic                                  acc_valid,
    input  logic [ADDR_W-1:0]                     acc_addr,
    input  logic [MASTER_W-1:0]                   acc_master,
    input  logic [1:0]                            acc_kind,
    input  logic                                  acc_super,
    input  logic [PID_W-1:0]                      acc_pid,
    input  logic [PORT_W-1:0]                     acc_port,
    output logic                                  resp_valid,
    output logic                                  resp_grant,
    output logic [NUM_PORTS-1:0]                  err_pend,
    input  logic [NUM_PORTS-1:0]                  err_clr,
    output logic [NUM_PORTS*ADDR_W-1:0]           err_addr,
    output logic [NUM_PORTS*MASTER_W-1:0]         err_master,
    output logic [NUM_PORTS*2-1:0]                err_attr,
    output logic [NUM_PORTS-1:0]                  err_write,
    output logic [NUM_PORTS*2-1:0]                err_class
);

    localparam int XW  = PRIV_MASTERS * XSLOT_W;
    localparam int RWW = (NUM_MASTERS - PRIV_MASTERS) * RWSLOT_W;

    logic [NUM_REGIONS-1:0] hit_v;
    logic [NUM_REGIONS-1:0] allow_v;
    logic                   grant;
    logic [1:0]             cls;
    logic                   deny_now;
    logic [1:0]             attr_now;
    logic                   write_now;

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
        rac_region_eval #(
            .ADDR_W      (ADDR_W),
            .PID_W       (PID_W),
            .MASTER_W    (MASTER_W),
            .PRIV_MASTERS(PRIV_MASTERS),
            .NUM_MASTERS (NUM_MASTERS),
            .GRAIN_BITS  (GRAIN_BITS)
        ) i_eval (
            .valid  (rgn_valid[r]),
            .lo     (rgn_lo[r*ADDR_W +: ADDR_W]),
            .hi     (rgn_hi[r*ADDR_W +: ADDR_W]),
            .xperm  (rgn_xperm[r*XW +: XW]),
            .rwperm (rgn_rwperm[r*RWW +: RWW]),
            .tag    (rgn_tag[r*PID_W +: PID_W]),
            .tagmask(rgn_tagmask[r*PID_W +: PID_W]),
            .addr   (acc_addr),
            .master (acc_master),
            .kind   (acc_kind),
            .sup    (acc_super),
            .pid    (acc_pid),
            .hit    (hit_v[r]),
            .allow  (allow_v[r])
        );
    end

    rac_verdict #(.NUM_REGIONS(NUM_REGIONS)) i_verdict (
        .prot_en(prot_en),
        .hit_v  (hit_v),
        .allow_v(allow_v),
        .grant  (grant),
        .cls    (cls)
    );

    assign deny_now  = acc_valid && prot_en && !grant;
    assign attr_now  = {acc_super, (acc_kind != KIND_FETCH)};
    assign write_now = (acc_kind == KIND_WRITE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_grant <= 1'b0;
        end else begin
            resp_valid <= acc_valid;
            resp_grant <= acc_valid && grant;
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        rac_port_log #(
            .ADDR_W  (ADDR_W),
            .MASTER_W(MASTER_W)
        ) i_log (
            .clk      (clk),
            .rst_n    (rst_n),
            .deny     (deny_now && (acc_port == PORT_W'(p))),
            .clr      (err_clr[NUM_PORTS-1-p]),
            .in_addr  (acc_addr),
            .in_master(acc_master),
            .in_attr  (attr_now),
            .in_write (write_now),
            .in_cls   (cls),
            .pend     (err_pend[NUM_PORTS-1-p]),
            .q_addr   (err_addr[p*ADDR_W +: ADDR_W]),
            .q_master (err_master[p*MASTER_W +: MASTER_W]),
            .q_attr   (err_attr[p*2 +: 2]),
            .q_write  (err_write[p]),
            .q_cls    (err_class[p*2 +: 2])
        );
    end

endmodule

// File: rtl/rac_checker.sv
module rac_checker #(
    parameter int ADDR_W    = 16,
    parameter int NUM_PORTS = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        prot_en,
    input logic                        acc_valid,
    input logic                        resp_valid,
    input logic                        resp_grant,
    input logic [NUM_PORTS-1:0]        err_pend,
    input logic [NUM_PORTS-1:0]        err_clr,
    input logic [NUM_PORTS*ADDR_W-1:0] err_addr,
    input logic [NUM_PORTS*2-1:0]      err_class
);

    AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> resp_valid);  // R6

    AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !resp_valid);  // R6

    AST_DISABLED_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !$past(prot_en)) |-> resp_grant);  // R7

    AST_FLAG_RISE_IS_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_pend & ~$past(err_pend)) != '0) |-> (resp_valid && !resp_grant && $past(prot_en)));  // R9

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (err_pend[NUM_PORTS-1-p] && !err_clr[NUM_PORTS-1-p])
            |=> $stable(err_addr[p*ADDR_W +: ADDR_W]));  // R10

        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (err_clr[NUM_PORTS-1-p] && !acc_valid) |=> !err_pend[NUM_PORTS-1-p]);  // R11

        AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            err_pend[NUM_PORTS-1-p] |-> (err_class[p*2 +: 2] != 2'd3));  // R8
    end

endmodule

bind region_access_checker rac_checker #(
    .ADDR_W   (ADDR_W),
    .NUM_PORTS(NUM_PORTS)
) i_rac_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .prot_en   (prot_en),
    .acc_valid (acc_valid),
    .resp_valid(resp_valid),
    .resp_grant(resp_grant),
    .err_pend  (err_pend),
    .err_clr   (err_clr),
    .err_addr  (err_addr),
    .err_class (err_class)
);

// File: tb/test_region_access_checker.sv
`timescale 1ns/1ps
module test_region_access_checker;

    localparam int NR = 4, AW = 16, PW = 8, MW = 3, PM = 4, NM = 8, NP = 5, GB = 5, PTW = 3;
    localparam int XW = PM * 6, RWW = (NM - PM) * 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prot_en = 1'b0;
    logic [NR-1:0]     rgn_valid = '0;
    logic [NR*AW-1:0]  rgn_lo = '0, rgn_hi = '0;
    logic [NR*XW-1:0]  rgn_xperm = '0;
    logic [NR*RWW-1:0] rgn_rwperm = '0;
    logic [NR*PW-1:0]  rgn_tag = '0, rgn_tagmask = '0;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [MW-1:0] acc_master = '0;
    logic [1:0]    acc_kind = '0;
    logic          acc_super = 1'b0;
    logic [PW-1:0] acc_pid = '0;
    logic [PTW-1:0] acc_port = '0;
    logic          resp_valid, resp_grant;
    logic [NP-1:0] err_pend;
    logic [NP-1:0] err_clr = '0;
    logic [NP*AW-1:0] err_addr;
    logic [NP*MW-1:0] err_master;
    logic [NP*2-1:0]  err_attr;
    logic [NP-1:0]    err_write;
    logic [NP*2-1:0]  err_class;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    region_access_checker i_region_access_checker (
        .clk(clk), .rst_n(rst_n), .prot_en(prot_en),
        .rgn_valid(rgn_valid), .rgn_lo(rgn_lo), .rgn_hi(rgn_hi),
        .rgn_xperm(rgn_xperm), .rgn_rwperm(rgn_rwperm),
        .rgn_tag(rgn_tag), .rgn_tagmask(rgn_tagmask),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_master(acc_master),
        .acc_kind(acc_kind), .acc_super(acc_super), .acc_pid(acc_pid), .acc_port(acc_port),
        .resp_valid(resp_valid), .resp_grant(resp_grant),
        .err_pend(err_pend), .err_clr(err_clr), .err_addr(err_addr),
        .err_master(err_master), .err_attr(err_attr), .err_write(err_write),
        .err_class(err_class)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wipe();
        rgn_valid = '0; rgn_xperm = '0; rgn_rwperm = '0; rgn_tag = '0; rgn_tagmask = '0;
    endtask

    task automatic set_rgn(input int r, input logic [AW-1:0] lo, input logic [AW-1:0] hi);
        rgn_valid[r] = 1'b1;
        rgn_lo[r*AW +: AW] = lo;
        rgn_hi[r*AW +: AW] = hi;
    endtask

    task automatic set_x(input int r, input int m, input logic [2:0] u, input logic [1:0] s, input logic pe);
        rgn_xperm[r*XW + m*6 +: 6] = {pe, s, u};
    endtask

    task automatic set_rw(input int r, input int m, input logic rd, input logic wr);
        rgn_rwperm[r*RWW + (m-PM)*2 +: 2] = {rd, wr};
    endtask

    task automatic access(input logic [AW-1:0] a, input int m, input logic [1:0] k,
                          input logic s, input logic [PW-1:0] pid, input int port,
                          input logic [NP-1:0] clr);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_master = MW'(m); acc_kind = k;
        acc_super = s; acc_pid = pid; acc_port = PTW'(port); err_clr = clr;
        @(negedge clk);
        acc_valid = 1'b0; err_clr = '0;
    endtask

    task automatic clear_all();
        @(negedge clk); err_clr = '1;
        @(negedge clk); err_clr = '0;
    endtask

    function automatic logic exp_priv(input logic [2:0] u, input logic [1:0] s, input logic sup, input logic [1:0] k);
        logic [2:0] e;
        if (!sup || s == 2'd3) e = u;
        else if (s == 2'd0) e = 3'b111;
        else if (s == 2'd1) e = 3'b101;
        else e = 3'b110;
        return (k == 2'd2) ? e[0] : (k == 2'd1) ? e[1] : e[2];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 pend", 32'(err_pend), 0);
        chk("R12 resp_valid", 32'(resp_valid), 0);
        chk("R12 resp_grant", 32'(resp_grant), 0);
        rst_n = 1'b1;

        // R7: disabled protection grants and logs nothing
        prot_en = 1'b0;
        access(16'h0400, 5, 2'd1, 1'b0, 8'h00, 1, '0);
        chk("R7 grant", 32'(resp_grant), 1);
        chk("R7 no log", 32'(err_pend), 0);
        prot_en = 1'b1;

        // R2/R3 sweep over privileged masters
        for (int m = 0; m < PM; m++)
            for (int u = 0; u < 8; u++)
                for (int s = 0; s < 4; s++)
                    for (int sp = 0; sp < 2; sp++)
                        for (int k = 0; k < 3; k++) begin
                            wipe();
                            set_rgn(0, 16'h0100, 16'h01FF);
                            set_x(0, m, 3'(u), 2'(s), 1'b0);
                            access(16'h0150, m, 2'(k), 1'(sp), 8'h00, 7, '0);
                            chk((sp == 1 && s != 3) ? "R3 super rights" : "R2 user rights",
                                32'(resp_grant), 32'(exp_priv(3'(u), 2'(s), 1'(sp), 2'(k))));
                        end

        // R4 sweep over plain masters
        for (int m = PM; m < NM; m++)
            for (int rw = 0; rw < 4; rw++)
                for (int k = 0; k < 3; k++) begin
                    wipe();
                    set_rgn(0, 16'h0100, 16'h01FF);
                    set_rw(0, m, rw[1], rw[0]);
                    access(16'h0150, m, 2'(k), 1'b1, 8'h00, 7, '0);
                    chk("R4 plain rights", 32'(resp_grant),
                        32'((k == 2) ? 0 : (k == 1) ? rw[0] : rw[1]));
                end

        // R1 bounds with granule widening
        wipe();
        set_rgn(1, 16'h0123, 16'h0145);
        set_x(1, 0, 3'd7, 2'd3, 1'b0);
        access(16'h011F, 0, 2'd0, 1'b0, 8'h00, 7, '0); chk("R1 below", 32'(resp_grant), 0);
        access(16'h0120, 0, 2'd0, 1'b0, 8'h00, 7, '0); chk("R1 low edge", 32'(resp_grant), 1);
        access(16'h015F, 0, 2'd0, 1'b0, 8'h00, 7, '0); chk("R1 high edge", 32'(resp_grant), 1);
        access(16'h0160, 0, 2'd0, 1'b0, 8'h00, 7, '0); chk("R1 above", 32'(resp_grant), 0);
        rgn_valid[1] = 1'b0;
        access(16'h0130, 0, 2'd0, 1'b0, 8'h00, 7, '0); chk("R1 invalid", 32'(resp_grant), 0);

        // R5 process-ID qualify
        wipe();
        set_rgn(0, 16'h0200, 16'h02FF);
        set_x(0, 1, 3'd7, 2'd3, 1'b1);
        rgn_tag[0 +: PW] = 8'hA5; rgn_tagmask[0 +: PW] = 8'h0F;
        access(16'h0210, 1, 2'd0, 1'b0, 8'hA0, 7, '0); chk("R5 masked match", 32'(resp_grant), 1);
        access(16'h0210, 1, 2'd0, 1'b0, 8'hB5, 7, '0); chk("R5 mismatch", 32'(resp_grant), 0);
        set_x(0, 1, 3'd7, 2'd3, 1'b0);
        access(16'h0210, 1, 2'd0, 1'b0, 8'hB5, 7, '0); chk("R5 qualify off", 32'(resp_grant), 1);

        // R6 any hitting region allows; response timing
        wipe();
        set_rgn(0, 16'h0300, 16'h03FF);
        set_rgn(2, 16'h0300, 16'h033F);
        set_rw(2, 6, 1'b1, 1'b0);
        access(16'h0310, 6, 2'd0, 1'b0, 8'h00, 7, '0);
        chk("R6 resp_valid", 32'(resp_valid), 1);
        chk("R6 overlap grant", 32'(resp_grant), 1);
        @(negedge clk);
        chk("R6 resp_valid drops", 32'(resp_valid), 0);

        // R8/R9 capture, class 0, port 0 -> bit 4
        clear_all();
        wipe();
        access(16'h2000, 2, 2'd2, 1'b0, 8'h00, 0, '0);
        chk("R9 flag order port0", 32'(err_pend), 32'h10);
        chk("R8 class none", 32'(err_class[0 +: 2]), 0);
        chk("R9 addr", 32'(err_addr[0 +: AW]), 32'h2000);
        chk("R9 master", 32'(err_master[0 +: MW]), 2);
        chk("R9 attr user fetch", 32'(err_attr[0 +: 2]), 0);
        chk("R9 fetch as read", 32'(err_write[0]), 0);

        // class 1, port 4 -> bit 0
        set_rgn(0, 16'h3000, 16'h30FF);
        access(16'h3004, 5, 2'd1, 1'b1, 8'h00, 4, '0);
        chk("R9 flag order port4", 32'(err_pend), 32'h11);
        chk("R8 class single", 32'(err_class[8 +: 2]), 1);
        chk("R9 attr super data", 32'(err_attr[8 +: 2]), 3);
        chk("R9 write", 32'(err_write[4]), 1);
        chk("R9 master5", 32'(err_master[12 +: MW]), 5);

        // R10 hold on port 4
        access(16'h3080, 6, 2'd0, 1'b0, 8'h00, 4, '0);
        chk("R10 addr held", 32'(err_addr[4*AW +: AW]), 32'h3004);
        chk("R10 master held", 32'(err_master[12 +: MW]), 5);

        // class 2 on port 2, then clear and reload
        set_rgn(1, 16'h3000, 16'h303F);
        access(16'h3008, 5, 2'd0, 1'b0, 8'h00, 2, '0);
        chk("R8 class multi", 32'(err_class[4 +: 2]), 2);
        chk("R9 port2 flag", 32'(err_pend[2]), 1);
        chk("R9 attr user data", 32'(err_attr[4 +: 2]), 1);
        access(16'h3010, 5, 2'd1, 1'b0, 8'h00, 2, 5'b00100);
        chk("R11 reload keeps flag", 32'(err_pend[2]), 1);
        chk("R11 reload addr", 32'(err_addr[2*AW +: AW]), 32'h3010);
        @(negedge clk); err_clr = 5'b00001;
        @(negedge clk); err_clr = '0;
        chk("R11 clear port4 only", 32'(err_pend), 32'h14);
        @(negedge clk); err_clr = 5'b00000;
        chk("R11 no clear no effect", 32'(err_pend), 32'h14);
        clear_all();
        chk("R11 clear all", 32'(err_pend), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule